// File: doc/BRIEF.md
# Frame Buffer Scan-Out Reader

This block pulls an 8-bit-per-pixel frame out of external memory and turns it into a pixel stream for a display. The default frame is 1280x720 at 60 frames per second. It talks to a memory controller through a plain command port and a read-data FIFO port. Each command asks for a fixed burst of 32-bit words, 16 by default and 8 as the alternative setting. Returned words are drained at once into a small local word buffer. An unpacker then hands out one byte per clock while the display enable input is high. The block runs on the pixel clock, and a frame-start strobe from the video timing generator starts each frame.

Requests are throttled in two ways so the read path cannot jam. First, a command is issued only after the controller reports its command queue empty, which keeps at most one command in flight. Second, a credit count covers words requested but not yet shown, and that count may never exceed the local buffer depth. The buffer depth is itself no larger than the controller's 64-word read FIFO. If the display asks for a pixel while the buffer is empty, the block outputs zero and raises a sticky underflow flag.

The request state machine has five states:
- REQ_IDLE: after reset, waiting for the first frame-start.
- REQ_HOLD: waits for queue empty plus buffer room, or for the frame to finish.
- REQ_ISSUE: drives the one-cycle command pulse.
- REQ_SETTLE: a one-cycle pause that lets the queue-empty flag update.
- REQ_DONE: the whole frame has been requested.

Transitions: frame-start moves any state to REQ_HOLD. REQ_HOLD goes to REQ_ISSUE when the queue is empty and there is room, and to REQ_DONE when all words have been requested. REQ_ISSUE always goes to REQ_SETTLE, and REQ_SETTLE always goes back to REQ_HOLD.

The pixel state machine records what was shown in the last cycle, in one of three states:
- PX_BLANK: display enable was low.
- PX_SHOW: a byte was presented.
- PX_STARVE: display enable was high but the buffer was empty.

Top module: `fb_scanout`

## Requirements
- R1: After reset, cmd_en, pix_valid, pix_out and underflow are all 0, and no command is issued until the first frame_start.
- R2: cmd_en is a single-cycle pulse. It is raised only when cmd_empty was high in the previous cycle, and it is never raised in two consecutive cycles.
- R3: Within a frame, commands carry ascending byte addresses in cmd_addr, stepping by BURST*4, and cmd_words equals BURST. After exactly H_ACTIVE*V_ACTIVE/4 words have been requested, no more commands are issued.
- R4: rd_en is high in every cycle in which rd_empty is low, so the read-data FIFO is drained continuously.
- R5: The number of words requested but not yet fully shown never exceeds BUF_WORDS (which is at most 64), and the local buffer never overflows.
- R6: Pixels come out in ascending byte-address order. Within each 32-bit word, bits [7:0] come first, then [15:8], then [23:16], then [31:24].
- R7: pix_valid is high exactly in the cycle after a cycle in which de was sampled high. pix_out is 0 whenever pix_valid is low.
- R8: When de is sampled high with the local buffer empty, the next cycle shows pix_valid=1 and pix_out=0, and underflow is set. The flag stays set until reset.
- R9: Each frame_start restarts requests at byte address 0.
- R10: Once a frame's words have all been requested, no further command is issued before the next frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe that starts a new frame |
| de | input | 1 | Display enable for the active area |
| cmd_empty | input | 1 | Memory controller command queue is empty |
| cmd_en | output | 1 | Read command strobe |
| cmd_addr | output | ADDR_W | Byte address of the burst |
| cmd_words | output | 7 | Burst length in words |
| rd_empty | input | 1 | Read-data FIFO is empty |
| rd_data | input | 32 | Read-data FIFO head word (first-word fall-through) |
| rd_en | output | 1 | Pop strobe for the read-data FIFO |
| pix_out | output | 8 | Pixel value |
| pix_valid | output | 1 | pix_out carries an active-area pixel |
| underflow | output | 1 | Sticky local buffer underflow flag |

## Verification
Pixel results are due one clock after the edge that samples de: pix_valid and pix_out are registered once and do not depend on the request path. A command pulse appears in the cycle after REQ_HOLD sees cmd_empty high, and the next command can come no sooner than two cycles later. The bench applies inputs just after a rising edge and samples every output at the falling edge. It compares pix_valid with the de value it drove one cycle earlier, and checks each command against the bench's running address, word count and credit total at the moment of the pulse. Blanking lengths and memory latency are randomized from a fixed seed. Directed cases cover the reset state, a frame restart, the end-of-frame stop, and display enable with an empty buffer.

// File: rtl/fbs_pkg.sv
`timescale 1ns/1ps
package fbs_pkg;
    typedef enum logic [2:0] {
        REQ_IDLE,
        REQ_HOLD,
        REQ_ISSUE,
        REQ_SETTLE,
        REQ_DONE
    } req_state_t;

    typedef enum logic [1:0] {
        PX_BLANK,
        PX_SHOW,
        PX_STARVE
    } px_state_t;
endpackage

// File: rtl/fbs_req_fsm.sv
`timescale 1ns/1ps
module fbs_req_fsm
    import fbs_pkg::*;
#(
    parameter int BURST       = 16,
    parameter int BUF_WORDS   = 32,
    parameter int TOTAL_WORDS = 230400,
    parameter int ADDR_W      = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              cmd_empty,
    input  logic              word_pop,
    output logic              cmd_en,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int CW   = $clog2(BUF_WORDS + 1);
    localparam int TW   = $clog2(TOTAL_WORDS + 1);
    localparam int STEP = BURST * 4;

    req_state_t        state, nxt;
    logic [TW-1:0]     words_req;
    logic [ADDR_W-1:0] addr;
    logic [CW-1:0]     reserved;
    logic              room;

    assign room = (reserved <= CW'(BUF_WORDS - BURST));

    always_comb begin
        nxt = state;
        unique case (state)
            REQ_IDLE:   nxt = REQ_IDLE;
            REQ_HOLD: begin
                if (words_req == TW'(TOTAL_WORDS)) nxt = REQ_DONE;
                else if (cmd_empty && room)        nxt = REQ_ISSUE;
            end
            REQ_ISSUE:  nxt = REQ_SETTLE;
            REQ_SETTLE: nxt = REQ_HOLD;
            REQ_DONE:   nxt = REQ_DONE;
        endcase
        if (frame_start) nxt = REQ_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= REQ_IDLE;
            words_req <= '0;
            addr      <= '0;
            reserved  <= '0;
        end else begin
            state    <= nxt;
            reserved <= reserved + ((state == REQ_ISSUE) ? CW'(BURST) : CW'(0))
                                 - (word_pop ? CW'(1) : CW'(0));
            if (frame_start) begin
                words_req <= '0;
                addr      <= '0;
            end else if (state == REQ_ISSUE) begin
                words_req <= words_req + TW'(BURST);
                addr      <= addr + ADDR_W'(STEP);
            end
        end
    end

    always_comb begin
        cmd_en   = (state == REQ_ISSUE);
        cmd_addr = addr;
    end

    // R5: credit never exceeds the local buffer depth
    assert_credit_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reserved <= CW'(BUF_WORDS));
    // R2: command is a single-cycle pulse
    assert_cmd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en |=> !cmd_en);
    // R10: nothing is requested once the frame is complete
    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REQ_DONE && !frame_start) |=> !cmd_en);
endmodule

// File: rtl/fbs_pixbuf.sv
`timescale 1ns/1ps
module fbs_pixbuf
    import fbs_pkg::*;
#(
    parameter int BUF_WORDS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic [31:0] push_data,
    input  logic        de,
    output logic [7:0]  pix_out,
    output logic        pix_valid,
    output logic        underflow,
    output logic        word_pop
);
    localparam int AW = $clog2(BUF_WORDS);

    logic [31:0] mem [BUF_WORDS];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   cnt;
    logic [1:0]    byte_idx;
    logic          have, take;
    px_state_t     state, nxt;

    assign have     = (cnt != '0);
    assign take     = de && have;
    assign word_pop = take && (byte_idx == 2'd3);

    always_comb begin
        nxt = state;
        unique case (state)
            PX_BLANK, PX_SHOW, PX_STARVE: begin
                if (!de)       nxt = PX_BLANK;
                else if (have) nxt = PX_SHOW;
                else           nxt = PX_STARVE;
            end
            default: nxt = PX_BLANK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= PX_BLANK;
            wptr      <= '0;
            rptr      <= '0;
            cnt       <= '0;
            byte_idx  <= '0;
            pix_out   <= '0;
            underflow <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= cnt + (push ? (AW+1)'(1) : '0) - (word_pop ? (AW+1)'(1) : '0);
            if (push)     wptr <= wptr + 1'b1;
            if (word_pop) rptr <= rptr + 1'b1;
            if (take)     byte_idx <= byte_idx + 2'd1;
            pix_out   <= take ? mem[rptr][{byte_idx, 3'b000} +: 8] : 8'h00;
            underflow <= underflow | (de && !have);
        end
    end

    always_comb pix_valid = (state != PX_BLANK);

    // R5: the local buffer never receives a word when full
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt < (AW+1)'(BUF_WORDS)));
    // R7: a sampled enable yields a valid pixel next cycle
    assert_valid_follows_de_R7: assert property (@(posedge clk) disable iff (!rst_n)
        de |=> pix_valid);
    assert_blank_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !de |=> (!pix_valid && pix_out == 8'h00));
    // R8: underflow stays set
    assert_underflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
endmodule

// File: rtl/fb_scanout.sv
`timescale 1ns/1ps
module fb_scanout #(
    parameter int H_ACTIVE  = 1280,
    parameter int V_ACTIVE  = 720,
    parameter int BURST     = 16,
    parameter int BUF_WORDS = 32,
    parameter int ADDR_W    = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              de,
    input  logic              cmd_empty,
    output logic              cmd_en,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [6:0]        cmd_words,
    input  logic              rd_empty,
    input  logic [31:0]       rd_data,
    output logic              rd_en,
    output logic [7:0]        pix_out,
    output logic              pix_valid,
    output logic              underflow
);
    localparam int TOTAL_WORDS = (H_ACTIVE * V_ACTIVE) / 4;

    logic word_pop;

    assign rd_en     = !rd_empty;
    assign cmd_words = 7'(BURST);

    fbs_req_fsm #(
        .BURST      (BURST),
        .BUF_WORDS  (BUF_WORDS),
        .TOTAL_WORDS(TOTAL_WORDS),
        .ADDR_W     (ADDR_W)
    ) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .cmd_empty  (cmd_empty),
        .word_pop   (word_pop),
        .cmd_en     (cmd_en),
        .cmd_addr   (cmd_addr)
    );

    fbs_pixbuf #(
        .BUF_WORDS(BUF_WORDS)
    ) u_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rd_en),
        .push_data(rd_data),
        .de       (de),
        .pix_out  (pix_out),
        .pix_valid(pix_valid),
        .underflow(underflow),
        .word_pop (word_pop)
    );

    // R2: a command only follows a cycle with an empty queue
    assert_cmd_after_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en |-> $past(cmd_empty));
endmodule

// File: tb/test_fb_scanout.sv
`timescale 1ns/1ps
module test_fb_scanout;
    localparam int CLK_PERIOD = 10;
    localparam int H     = 32;
    localparam int V     = 8;
    localparam int BURST = 8;
    localparam int BUF   = 16;
    localparam int TOTAL = H * V / 4;

    logic        clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, de = 1'b0;
    logic        cmd_empty, cmd_en, rd_empty, rd_en, pix_valid, underflow;
    logic [29:0] cmd_addr;
    logic [6:0]  cmd_words;
    logic [31:0] rd_data;
    logic [7:0]  pix_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    fb_scanout #(.H_ACTIVE(H), .V_ACTIVE(V), .BURST(BURST), .BUF_WORDS(BUF), .ADDR_W(30)) i_fb_scanout (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .de(de),
        .cmd_empty(cmd_empty), .cmd_en(cmd_en), .cmd_addr(cmd_addr), .cmd_words(cmd_words),
        .rd_empty(rd_empty), .rd_data(rd_data), .rd_en(rd_en),
        .pix_out(pix_out), .pix_valid(pix_valid), .underflow(underflow)
    );

    int n_cmp = 0, n_bad = 0;
    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fpix(int p);
        return 8'((p * 37) ^ (p >> 5));
    endfunction
    function automatic logic [31:0] mkword(int w);
        return {fpix(4*w+3), fpix(4*w+2), fpix(4*w+1), fpix(4*w)};
    endfunction

    // memory controller model: one queued command, FWFT read FIFO of 64 words
    logic [31:0] rq [64];
    int rq_cnt = 0, rq_w = 0, rq_r = 0, pend_lat = 0, pend_word = 0;
    bit pend = 1'b0;
    assign cmd_empty = !pend;
    assign rd_empty  = (rq_cnt == 0);
    assign rd_data   = rq[rq_r];

    always @(posedge clk) begin
        int pops, pushes;
        if (!rst_n) begin
            rq_cnt <= 0; rq_w <= 0; rq_r <= 0; pend <= 1'b0;
        end else begin
            pops   = (rd_en && rq_cnt > 0) ? 1 : 0;
            pushes = 0;
            if (cmd_en) begin
                pend      <= 1'b1;
                pend_word <= int'(cmd_addr) / 4;
                pend_lat  <= 2 + int'($urandom % 5);
            end else if (pend) begin
                if (pend_lat == 0) begin
                    pushes = BURST;
                    for (int i = 0; i < BURST; i++) rq[(rq_w + i) % 64] <= mkword(pend_word + i);
                    rq_w <= (rq_w + BURST) % 64;
                    pend <= 1'b0;
                end else pend_lat <= pend_lat - 1;
            end
            rq_r   <= (rq_r + pops) % 64;
            rq_cnt <= rq_cnt + pushes - pops;
        end
    end

    // monitor, sampling at the falling edge
    int  exp_addr = 0, req_words = 0, pix_idx = 0;
    bit  frame_active = 1'b0, check_pix = 1'b1, de_prev = 1'b0, cmd_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            de_prev  = 1'b0;
            cmd_prev = 1'b0;
        end else begin
            chk(rq_cnt <= 64, "R5 read fifo overflow", rq_cnt, 64);
            if (rq_cnt > 0) chk(rd_en == 1'b1, "R4 drain", int'(rd_en), 1);
            if (cmd_en) begin
                chk(frame_active, "R10 command before frame", 0, 1);
                chk(cmd_empty == 1'b1, "R2 queue not empty", int'(cmd_empty), 1);
                chk(!cmd_prev, "R2 pulse width", int'(cmd_prev), 0);
                if (req_words == 0)
                    chk(int'(cmd_addr) == 0, "R9 restart address", int'(cmd_addr), 0);
                else
                    chk(int'(cmd_addr) == exp_addr, "R3 address", int'(cmd_addr), exp_addr);
                chk(int'(cmd_words) == BURST, "R3 burst length", int'(cmd_words), BURST);
                exp_addr  += BURST * 4;
                req_words += BURST;
                chk(req_words <= TOTAL, "R10 overrun", req_words, TOTAL);
                chk(req_words - pix_idx / 4 <= BUF, "R5 credit", req_words - pix_idx / 4, BUF);
            end
            cmd_prev = cmd_en;
            chk(pix_valid == de_prev, "R7 valid timing", int'(pix_valid), int'(de_prev));
            if (!pix_valid) chk(pix_out == 8'h00, "R7 blank value", int'(pix_out), 0);
            else if (check_pix) begin
                chk(pix_out == fpix(pix_idx), "R6 pixel", int'(pix_out), int'(fpix(pix_idx)));
                pix_idx++;
            end
            de_prev = de;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic start_frame();
        frame_start = 1'b1;
        exp_addr = 0; req_words = 0; pix_idx = 0; frame_active = 1'b1;
        tick();
        frame_start = 1'b0;
    endtask

    task automatic run_frame();
        for (int ln = 0; ln < V; ln++) begin
            de = 1'b1;
            repeat (H) tick();
            de = 1'b0;
            repeat (4 + int'($urandom % 9)) tick();
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) tick();
        // R1: reset state
        chk(cmd_en == 1'b0,   "R1 cmd_en",    int'(cmd_en), 0);
        chk(pix_valid == 1'b0, "R1 pix_valid", int'(pix_valid), 0);
        chk(pix_out == 8'h00, "R1 pix_out",   int'(pix_out), 0);
        chk(underflow == 1'b0, "R1 underflow", int'(underflow), 0);
        rst_n = 1'b1;
        repeat (20) tick();
        chk(req_words == 0, "R1 idle before frame", req_words, 0);

        for (int f = 0; f < 3; f++) begin
            start_frame();
            repeat (40) tick();
            run_frame();
            repeat (30) tick();
            chk(req_words == TOTAL, "R3 words per frame", req_words, TOTAL);
            chk(pix_idx == H * V, "R6 pixel count", pix_idx, H * V);
            chk(underflow == 1'b0, "R8 no underflow", int'(underflow), 0);
            repeat (20) tick();
            chk(req_words == TOTAL, "R10 quiet after frame", req_words, TOTAL);
        end

        // R8: display enable with empty buffer
        check_pix = 1'b0;
        rst_n = 1'b0;
        repeat (3) tick();
        chk(underflow == 1'b0, "R1 underflow after reset", int'(underflow), 0);
        rst_n = 1'b1;
        tick();
        start_frame();
        de = 1'b1;
        tick();
        chk(pix_valid == 1'b1, "R8 starve valid", int'(pix_valid), 1);
        chk(pix_out == 8'h00,  "R8 starve value", int'(pix_out), 0);
        chk(underflow == 1'b1, "R8 flag set", int'(underflow), 1);
        repeat (3) tick();
        de = 1'b0;
        repeat (30) tick();
        chk(underflow == 1'b1, "R8 flag sticky", int'(underflow), 1);
        rst_n = 1'b0;
        tick();
        chk(underflow == 1'b0, "R1 flag cleared by reset", int'(underflow), 0);
        summary();
        $finish;
    end
endmodule